// File: doc/BRIEF.md
# Pipelined Radix-4 Priority Encoder

This block turns a vector of N request bits into two results: a flag that says whether any request was asserted, and the binary position of the asserted request with the lowest position. Position 0 has the highest priority. The vector is reduced by a tree of radix-4 levels, and every level ends in a register. As a result, the critical path is one small encoder and one multiplexer, whatever the value of N.

The first level splits the input into groups of four bits. For each group it produces a 2-bit position and a hit flag. Each later level takes four (position, flag) pairs from the level below. A 4-to-2 priority encoder over the four flags picks a child, and the encoder output becomes the two new high-order index bits above the position of that child. When N is not a power of four, the missing inputs are padded with zeros. The block accepts one vector per clock and produces one answer per clock.

A typical use is to pick the winner among many parallel match lines, where a fixed order decides which line wins.

Top module: `prio_tree_enc`

## Requirements
- R1: When at least one request bit is asserted, `idx_o` gives the lowest-numbered asserted bit of the vector. Bit k of `req_i` maps to index value k.
- R2: `hit_o` is 1 exactly when the vector that was presented LEVELS cycles earlier had at least one asserted bit. LEVELS is ceil(log4 N), with a minimum of 1.
- R3: The latency from `req_i` to `hit_o`/`idx_o` is exactly LEVELS rising clock edges. A different vector may be applied on every cycle, and each answer belongs only to its own vector.
- R4: For an all-zero vector, `hit_o` is 0 and `idx_o` is 0.
- R5: `idx_o` is ceil(log2 N) bits wide, with a minimum of 1. For N=32 the tree yields 6 bits and the top bit is dropped. The highest input (bit 31) is reported as 31.
- R6: While `rst_n` is low, all pipeline registers are cleared and the outputs are 0, whatever `req_i` is. After release, the outputs stay 0 until the first vector has travelled LEVELS edges.
- R7: When N is not a power of four, the padded positions never win and never set `hit_o`. For example, with N=6 every one of the 64 input vectors gives the correct answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N | Request bits; bit 0 has the highest priority |
| hit_o | output | 1 | At least one request was asserted in the vector LEVELS cycles earlier |
| idx_o | output | ceil(log2 N) | Position of the winning request, 0 when there is none |

## Verification
Both results, `hit_o` and `idx_o`, are due exactly LEVELS rising edges after a vector is applied: three edges for N=32 and two edges for N=6. The bench drives a new vector on every falling edge and keeps a history of all the vectors it has applied. On each falling edge it compares the outputs against the entry from LEVELS vectors earlier. Entries from before the first vector count as zero, so any extra or missing register stage shows up as a mismatch.

// File: rtl/prio_pkg.sv
package prio_pkg;

    // Number of radix-4 levels needed to cover n inputs (at least one)
    function automatic int levels_for(input int n);
        int lv;
        int cap;
        lv  = 1;
        cap = 4;
        while (cap < n) begin
            cap = cap * 4;
            lv  = lv + 1;
        end
        return lv;
    endfunction

    // Width of the reported index (at least one bit)
    function automatic int idx_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/quad_leaf_enc.sv
// Four request bits -> 2-bit position of the lowest asserted bit plus any-flag
module quad_leaf_enc (
    input  logic [3:0] req,
    output logic [1:0] pos,
    output logic       hit
);
    always_comb begin
        pos = 2'd0;
        if (req[0])      pos = 2'd0;
        else if (req[1]) pos = 2'd1;
        else if (req[2]) pos = 2'd2;
        else if (req[3]) pos = 2'd3;
        hit = |req;
    end
endmodule

// File: rtl/quad_merge_enc.sv
// Combines four (index, flag) children into one wider (index, flag)
module quad_merge_enc #(
    parameter int W = 2
) (
    input  logic [3:0]     hits,
    input  logic [4*W-1:0] idx,
    output logic [W+1:0]   idx_o,
    output logic           hit
);
    logic [1:0] sel;

    quad_leaf_enc i_sel (
        .req (hits),
        .pos (sel),
        .hit (hit)
    );

    always_comb begin
        idx_o = {sel, idx[sel*W +: W]};
    end
endmodule

// File: rtl/prio_tree_enc.sv
module prio_tree_enc
    import prio_pkg::*;
#(
    parameter int N = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              req_i,
    output logic                      hit_o,
    output logic [idx_width(N)-1:0]   idx_o
);
    localparam int LEVELS = levels_for(N);
    localparam int PADN   = 4 ** LEVELS;
    localparam int IDXW   = idx_width(N);
    localparam int TOPW   = 2 * LEVELS;

    logic [PADN-1:0] req_pad;
    logic            top_hit;
    logic [TOPW-1:0] top_idx;

    always_comb begin
        req_pad        = '0;
        req_pad[N-1:0] = req_i;
    end

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
        localparam int NODES = PADN >> (2 * (lv + 1));
        localparam int W     = 2 * (lv + 1);

        typedef struct packed {
            logic [NODES-1:0]   hit;
            logic [NODES*W-1:0] idx;
        } lvl_t;

        lvl_t               lvl_d;
        lvl_t               lvl_q;
        logic [NODES-1:0]   node_hit;
        logic [NODES*W-1:0] node_idx;

        for (genvar nd = 0; nd < NODES; nd++) begin : g_node
            if (lv == 0) begin : g_leaf
                quad_leaf_enc i_leaf (
                    .req (req_pad[4*nd +: 4]),
                    .pos (node_idx[nd*W +: W]),
                    .hit (node_hit[nd])
                );
            end else begin : g_merge
                quad_merge_enc #(.W(W - 2)) i_merge (
                    .hits  (g_lvl[lv-1].lvl_q.hit[4*nd +: 4]),
                    .idx   (g_lvl[lv-1].lvl_q.idx[4*nd*(W-2) +: 4*(W-2)]),
                    .idx_o (node_idx[nd*W +: W]),
                    .hit   (node_hit[nd])
                );
            end
        end

        always_comb begin
            lvl_d     = lvl_q;
            lvl_d.hit = node_hit;
            lvl_d.idx = node_idx;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= '0;
            else        lvl_q <= lvl_d;
        end

        if (lv == LEVELS - 1) begin : g_top
            assign top_hit = lvl_q.hit[0];
            assign top_idx = lvl_q.idx;
        end
    end

    assign hit_o = top_hit;
    assign idx_o = top_idx[IDXW-1:0];

endmodule

// File: rtl/prio_tree_enc_chk.sv
module prio_tree_enc_chk
    import prio_pkg::*;
#(
    parameter int N = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N-1:0]            req_i,
    input  logic                    hit_o,
    input  logic [idx_width(N)-1:0] idx_o
);
    localparam int LEVELS = levels_for(N);
    localparam int CNTW   = $clog2(LEVELS + 1) + 1;

    logic [N-1:0]    req_hist [LEVELS];
    logic [CNTW-1:0] fill;
    logic            filled;
    logic            ref_any;
    int              ref_first;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill <= '0;
            for (int i = 0; i < LEVELS; i++) req_hist[i] <= '0;
        end else begin
            if (fill < CNTW'(LEVELS)) fill <= fill + 1'b1;
            req_hist[0] <= req_i;
            for (int i = 1; i < LEVELS; i++) req_hist[i] <= req_hist[i-1];
        end
    end

    always_comb begin
        filled    = (fill >= CNTW'(LEVELS));
        ref_any   = |req_hist[LEVELS-1];
        ref_first = 0;
        for (int i = N - 1; i >= 0; i--)
            if (req_hist[LEVELS-1][i]) ref_first = i;
    end

    AST_HIT_MATCHES_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        filled |-> (hit_o == ref_any)); // R2

    AST_IDX_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (filled && hit_o) |-> (int'(idx_o) == ref_first)); // R1

    AST_IDLE_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (idx_o == '0)); // R4

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (int'(idx_o) < N)); // R5

    AST_EARLY_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !filled |-> !hit_o); // R6

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEARS: assert (!hit_o && idx_o == '0); // R6
        end
    end

endmodule

bind prio_tree_enc prio_tree_enc_chk #(.N(N)) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (req_i),
    .hit_o (hit_o),
    .idx_o (idx_o)
);

// File: tb/test_prio_tree_enc.sv
module test_prio_tree_enc;
    localparam int CLK_PERIOD = 10;
    localparam int LAT_A      = 3;   // N=32
    localparam int LAT_B      = 2;   // N=6
    localparam int HMAX       = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req = '0;
    logic        hit_a;
    logic [4:0]  idx_a;
    logic        hit_b;
    logic [2:0]  idx_b;

    int          n_tests = 0;
    int          n_fail  = 0;
    int          cyc     = 0;
    string       phase_tag = "R1";
    logic [31:0] hist [HMAX];

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_tree_enc #(.N(32)) i_prio_tree_enc (
        .clk (clk), .rst_n (rst_n), .req_i (req),
        .hit_o (hit_a), .idx_o (idx_a)
    );

    prio_tree_enc #(.N(6)) i_prio_tree_enc_n6 (
        .clk (clk), .rst_n (rst_n), .req_i (req[5:0]),
        .hit_o (hit_b), .idx_o (idx_b)
    );

    function automatic int lowest_set(input logic [31:0] v, input int n);
        int r;
        r = 0;
        for (int i = n - 1; i >= 0; i--) if (v[i]) r = i;
        return r;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic check_outputs();
        logic [31:0] va;
        logic [31:0] vb;
        va = (cyc >= LAT_A) ? hist[cyc-LAT_A] : 32'h0;
        vb = (cyc >= LAT_B) ? (hist[cyc-LAT_B] & 32'h3f) : 32'h0;
        // R2 / R3: flag due exactly LAT edges after the vector
        check("R2 hit N32", int'(hit_a), int'(|va));
        check((va == 0) ? "R4 idx N32" : phase_tag, int'(idx_a), lowest_set(va, 32));
        // R7: padded configuration
        check("R7 hit N6", int'(hit_b), int'(|vb));
        check((vb == 0) ? "R4 idx N6" : "R7 idx N6", int'(idx_b), lowest_set(vb, 6));
    endtask

    task automatic step(input logic [31:0] v);
        @(negedge clk);
        check_outputs();
        req = v;
        hist[cyc] = v;
        cyc++;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        // R6: outputs held at zero under reset despite active requests
        req = 32'hffff_ffff;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R6 reset hit N32", int'(hit_a), 0);
            check("R6 reset idx N32", int'(idx_a), 0);
            check("R6 reset hit N6", int'(hit_b), 0);
            check("R6 reset idx N6", int'(idx_b), 0);
        end
        req = '0;
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R7: every 6-bit pattern, upper bits varied
        phase_tag = "R1 idx N32";
        for (int v = 0; v < 64; v++) step({v[5:0] ^ 6'h15, 20'h0, v[5:0], v[5:0]});
        for (int v = 0; v < 64; v++) step({26'h0, v[5:0]});

        // R5: each single bit, including the top one
        phase_tag = "R5 idx N32";
        for (int b = 0; b < 32; b++) step(32'h1 << b);
        // pairs with a higher bit set as well
        for (int b = 0; b < 31; b++) step((32'h1 << b) | 32'h8000_0000);
        step(32'h0);
        step(32'h8000_0000);

        // R3: back-to-back varied vectors with idle gaps
        phase_tag = "R3 idx N32";
        lf = 32'h1234_5678;
        for (int k = 0; k < 300; k++) begin
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >> 17);
            lf = lf ^ (lf << 5);
            if (k % 7 == 3) step(32'h0);
            else if (k % 3 == 0) step(lf & (lf >> 9) & (lf >> 3));
            else step(lf);
        end

        // flush so every applied vector is observed
        for (int i = 0; i < LAT_A + 1; i++) step(32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule